// File: doc/BRIEF.md
# Active-Lane Word Distributor

This block sits between the word selector of a multi-lane link transmitter and the physical lane drivers. Each cycle it receives a row of up to N words in transmit order, a tag per word marking it as control or data, a count of the meaningful words in the row, a frame-end flag, and an N-bit mask of the physical lanes that are currently up. It steers the words onto the live lanes in order, leaves dead lanes idle, and registers the result for the lane drivers.

Two rows get special handling. If the first word of a row is tagged as control, that word goes out on every live lane. If a data row closes a frame and carries fewer words than there are live lanes, the spare live lanes carry a padding control code. The padding code is a parameter.

Top module: `lane_dist`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `lane_valid`, `lane_ctrl` and `lane_words` is cleared on that edge.
- R2: The lane outputs change only at a rising clock edge and reflect the inputs present at that edge, so latency is exactly one cycle.
- R3: In a data row (tag bit 0 of `in_ctrl` is 0), word k (bits `[k*W +: W]` of `in_words`) goes to the lane that holds the (k+1)-th set bit of `lane_mask`, counting upward from lane 0. Lane i's word sits at `lane_words[i*W +: W]`.
- R4: A lane whose mask bit is 0 has `lane_valid` low, `lane_ctrl` low and an all-zero word.
- R5: In a data row that does not close a frame (`in_last` = 0), a live lane whose rank is at or above `in_count` is not valid and drives zero.
- R6: In a data row with `in_last` = 1, every live lane whose rank is at or above `in_count` is valid and carries the padding code `PAD_CODE` with its control flag set.
- R7: When `in_ctrl[0]` is 1, word 0 is sent on every live lane with the control flag set, and the other words and `in_count` have no effect.
- R8: In a data row, a lane carrying word k has `lane_ctrl` equal to `in_ctrl[k]`.
- R9: When `in_valid` is 0 at an edge, all lane outputs are zero after that edge.
- R10: When `in_count` exceeds the number of live lanes, the extra words are dropped and only the first M words are placed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A row is present this cycle |
| in_words | input | N*W | Selected words, word 0 in the low bits |
| in_ctrl | input | N | Control tag per word, bit k for word k |
| in_count | input | $clog2(N+1) | Number of meaningful words in the row |
| in_last | input | 1 | Row closes a data frame |
| lane_mask | input | N | Bit i high means physical lane i is live |
| lane_words | output | N*W | Word per physical lane, lane 0 in the low bits |
| lane_ctrl | output | N | Control flag per lane |
| lane_valid | output | N | Valid flag per lane |

## Verification
A wrong rank count shows up as a word placed on the wrong lane or repeated on two lanes. It appears on the first edge after a sparse mask such as 1011 or 0110 is applied, so the vectors use masks with gaps at several positions. A wrong padding or broadcast decision appears as a valid flag or control flag that differs from the mask on that same edge. Stale data from a missing clear appears on the first idle cycle after a busy one.

// File: rtl/lane_dist_pkg.sv
package lane_dist_pkg;

  // source chosen for one physical lane in one cycle
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_DATA  = 2'd1,
    SRC_PAD   = 2'd2,
    SRC_BCAST = 2'd3
  } lane_src_e;

endpackage

// File: rtl/lane_rank_calc.sv
module lane_rank_calc #(
  parameter int N  = 4,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]    mask,
  output logic [N*CW-1:0] ranks
);

  // rank of lane i = number of live lanes strictly below it
  for (genvar i = 0; i < N; i++) begin : g_rank
    logic [CW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < i; j++) begin
        acc = acc + CW'(mask[j]);
      end
    end
    assign ranks[i*CW +: CW] = acc;
  end

endmodule

// File: rtl/lane_slot.sv
module lane_slot
  import lane_dist_pkg::*;
#(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int CW = $clog2(N + 1),
  parameter logic [W-1:0] PAD_CODE = '1
) (
  input  logic          live,
  input  logic [CW-1:0] rank,
  input  logic          row_valid,
  input  logic          row_last,
  input  logic [CW-1:0] row_count,
  input  logic [N*W-1:0] row_words,
  input  logic [N-1:0]  row_tags,
  output logic [W-1:0]  nxt_word,
  output logic          nxt_ctrl,
  output logic          nxt_valid
);

  lane_src_e     src;
  logic [W-1:0]  picked_word;
  logic          picked_tag;

  // choose what this lane carries
  always_comb begin
    if (!row_valid || !live) begin
      src = SRC_IDLE;
    end else if (row_tags[0]) begin
      src = SRC_BCAST;
    end else if (rank < row_count) begin
      src = SRC_DATA;
    end else if (row_last) begin
      src = SRC_PAD;
    end else begin
      src = SRC_IDLE;
    end
  end

  // word mux indexed by rank
  always_comb begin
    picked_word = '0;
    picked_tag  = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (rank == CW'(k)) begin
        picked_word = row_words[k*W +: W];
        picked_tag  = row_tags[k];
      end
    end
  end

  always_comb begin
    unique case (src)
      SRC_DATA: begin
        nxt_word  = picked_word;
        nxt_ctrl  = picked_tag;
        nxt_valid = 1'b1;
      end
      SRC_PAD: begin
        nxt_word  = PAD_CODE;
        nxt_ctrl  = 1'b1;
        nxt_valid = 1'b1;
      end
      SRC_BCAST: begin
        nxt_word  = row_words[W-1:0];
        nxt_ctrl  = 1'b1;
        nxt_valid = 1'b1;
      end
      default: begin
        nxt_word  = '0;
        nxt_ctrl  = 1'b0;
        nxt_valid = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lane_dist.sv
module lane_dist #(
  parameter int N = 4,
  parameter int W = 8,
  parameter logic [W-1:0] PAD_CODE = 8'hBC,
  localparam int CW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_words,
  input  logic [N-1:0]   in_ctrl,
  input  logic [CW-1:0]  in_count,
  input  logic           in_last,
  input  logic [N-1:0]   lane_mask,
  output logic [N*W-1:0] lane_words,
  output logic [N-1:0]   lane_ctrl,
  output logic [N-1:0]   lane_valid
);

  logic [N*CW-1:0] ranks;
  logic [N*W-1:0]  nxt_words;
  logic [N-1:0]    nxt_ctrl;
  logic [N-1:0]    nxt_valid;

  lane_rank_calc #(.N(N), .CW(CW)) u_rank (
    .mask  (lane_mask),
    .ranks (ranks)
  );

  for (genvar i = 0; i < N; i++) begin : g_lane
    lane_slot #(.N(N), .W(W), .CW(CW), .PAD_CODE(PAD_CODE)) u_slot (
      .live      (lane_mask[i]),
      .rank      (ranks[i*CW +: CW]),
      .row_valid (in_valid),
      .row_last  (in_last),
      .row_count (in_count),
      .row_words (in_words),
      .row_tags  (in_ctrl),
      .nxt_word  (nxt_words[i*W +: W]),
      .nxt_ctrl  (nxt_ctrl[i]),
      .nxt_valid (nxt_valid[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_words <= '0;
      lane_ctrl  <= '0;
      lane_valid <= '0;
    end else begin
      lane_words <= nxt_words;
      lane_ctrl  <= nxt_ctrl;
      lane_valid <= nxt_valid;
    end
  end

endmodule

// File: rtl/lane_dist_chk.sv
module lane_dist_chk #(
  parameter int N = 4,
  parameter int W = 8,
  parameter int CW = $clog2(N + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [N-1:0]   in_ctrl,
  input logic           in_last,
  input logic [CW-1:0]  in_count,
  input logic [N-1:0]   lane_mask,
  input logic [N*W-1:0] lane_words,
  input logic [N-1:0]   lane_ctrl,
  input logic [N-1:0]   lane_valid
);

  logic idle_dirty;
  always_comb begin
    idle_dirty = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!lane_valid[i] && (lane_ctrl[i] || (lane_words[i*W +: W] != '0)))
        idle_dirty = 1'b1;
    end
  end

  // R4
  dead_lane_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (lane_valid & ~$past(lane_mask)) == '0);

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> !idle_dirty);

  // R7
  bcast_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ctrl[0]) |=> (lane_valid == $past(lane_mask)) && ((lane_ctrl & $past(lane_mask)) == $past(lane_mask)));

  // R6
  last_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ctrl[0] && in_last) |=> lane_valid == $past(lane_mask));

  // R9
  no_row_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (lane_valid == '0) && (lane_ctrl == '0) && (lane_words == '0));

  // R5
  valid_count_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ctrl[0] && !in_last) |=> $countones(lane_valid) <= int'($past(in_count)));

endmodule

bind lane_dist lane_dist_chk #(.N(N), .W(W), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ctrl    (in_ctrl),
  .in_last    (in_last),
  .in_count   (in_count),
  .lane_mask  (lane_mask),
  .lane_words (lane_words),
  .lane_ctrl  (lane_ctrl),
  .lane_valid (lane_valid)
);

// File: tb/lane_dist_test.sv
module lane_dist_test;
  localparam int N = 4;
  localparam int W = 8;
  localparam int CW = $clog2(N + 1);
  localparam int NV = 12;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [N*W-1:0] in_words = '0;
  logic [N-1:0]   in_ctrl = '0;
  logic [CW-1:0]  in_count = '0;
  logic           in_last = 1'b0;
  logic [N-1:0]   lane_mask = '0;
  logic [N*W-1:0] lane_words;
  logic [N-1:0]   lane_ctrl;
  logic [N-1:0]   lane_valid;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lane_dist #(.N(N), .W(W), .PAD_CODE(8'hBC)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_words(in_words),
    .in_ctrl(in_ctrl), .in_count(in_count), .in_last(in_last),
    .lane_mask(lane_mask), .lane_words(lane_words), .lane_ctrl(lane_ctrl),
    .lane_valid(lane_valid)
  );

  // mask, count, last, tags | exp valid, exp ctrl, exp words ; input words fixed 44_33_22_11
  localparam logic [51:0] VEC [NV] = '{
    {4'b1111, 3'd4, 1'b0, 4'b0000, 4'b1111, 4'b0000, 32'h44332211},
    {4'b1011, 3'd3, 1'b0, 4'b0000, 4'b1011, 4'b0000, 32'h33002211},
    {4'b0110, 3'd2, 1'b0, 4'b0000, 4'b0110, 4'b0000, 32'h00221100},
    {4'b1000, 3'd1, 1'b0, 4'b0000, 4'b1000, 4'b0000, 32'h11000000},
    {4'b1111, 3'd2, 1'b1, 4'b0000, 4'b1111, 4'b1100, 32'hBCBC2211},
    {4'b1101, 3'd1, 1'b1, 4'b0000, 4'b1101, 4'b1100, 32'hBCBC0011},
    {4'b1111, 3'd2, 1'b0, 4'b0000, 4'b0011, 4'b0000, 32'h00002211},
    {4'b1010, 3'd1, 1'b0, 4'b0001, 4'b1010, 4'b1010, 32'h11001100},
    {4'b0000, 3'd0, 1'b0, 4'b0000, 4'b0000, 4'b0000, 32'h00000000},
    {4'b1111, 3'd4, 1'b0, 4'b0100, 4'b1111, 4'b0100, 32'h44332211},
    {4'b0101, 3'd4, 1'b0, 4'b0000, 4'b0101, 4'b0000, 32'h00220011},
    {4'b1111, 3'd0, 1'b1, 4'b0000, 4'b1111, 4'b1111, 32'hBCBCBCBC}
  };
  string VREQ [NV] = '{"R3", "R3", "R3", "R4", "R6", "R6", "R5", "R7",
                       "R4", "R8", "R10", "R6"};

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [3:0] ev,
                           input logic [3:0] ec, input logic [31:0] ew);
    check(req, "valid", 32'(lane_valid), 32'(ev));
    check(req, "ctrl", 32'(lane_ctrl), 32'(ec));
    check(req, "words", lane_words, ew);
  endtask

  task automatic drive(input logic [3:0] m, input logic [2:0] c,
                       input logic l, input logic [3:0] t);
    in_valid  = 1'b1;
    lane_mask = m;
    in_count  = c;
    in_last   = l;
    in_ctrl   = t;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    in_words = 32'h44332211;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_all("R1", 4'b0000, 4'b0000, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check_all("R9", 4'b0000, 4'b0000, 32'h0);

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][51:48], VEC[v][47:45], VEC[v][44], VEC[v][43:40]);
      @(negedge clk);
      check_all(VREQ[v], VEC[v][39:36], VEC[v][35:32], VEC[v][31:0]);
    end

    // R7: other words and count ignored in a control row
    in_words = 32'h99887755;
    drive(4'b1111, 3'd2, 1'b1, 4'b0001);
    @(negedge clk);
    check_all("R7", 4'b1111, 4'b1111, 32'h55555555);

    // R2: change inputs mid-cycle, outputs hold until next edge
    in_words = 32'h44332211;
    drive(4'b0001, 3'd1, 1'b0, 4'b0000);
    #1;
    check_all("R2", 4'b1111, 4'b1111, 32'h55555555);
    @(negedge clk);
    check_all("R2", 4'b0001, 4'b0000, 32'h00000011);

    // R9: idle row clears everything
    drive(4'b1111, 3'd4, 1'b0, 4'b0000);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check_all("R9", 4'b0000, 4'b0000, 32'h0);

    // R1: reset mid-stream
    drive(4'b1111, 3'd4, 1'b0, 4'b0000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_all("R1", 4'b0000, 4'b0000, 32'h0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule